// File: doc/BRIEF.md
# DMA Transfer Length Controller

This block counts the data items of one DMA channel. Software loads a 16-bit remaining-item count through a byte-wide register port. It then selects byte or word transfers and, for word transfers, whether the byte length is odd. A start command arms the channel. The block then requests one transfer per item. Every acknowledged item takes exactly one off the count, whether it moved a byte or a word.

The run ends when an acknowledged item brings the count to zero. The busy status then drops, and a sticky done flag drives the interrupt line. The count is tested for zero only after a decrement, never when the channel is armed. A loaded value of zero therefore wraps on its first item and runs the full 65536 items.

For a word run with an odd byte length, software programs the rounded-up item count (N+1)/2. The block makes every item word-wide except the final one, which is byte-wide. For an even byte length in word mode, software programs N/2. In byte mode it programs N.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset, `irq` and `xfer_req` are low, and the control byte (address 2) reads 0: word mode 0, odd flag 0, busy 0, done 0.
- R2: While idle, the count is written and read as two bytes: address 0 holds bits 7:0 and address 1 holds bits 15:8.
- R3: At control address 2, bit 0 is word mode and bit 1 is the odd-byte flag. Both read back as written while idle. Writing 1 to bit 2 starts a run, and bit 2 reads as busy. Bit 3 reads as done, and writing 1 to bit 3 clears done.
- R4: `xfer_req` stays high from the start command until the last item is acknowledged. An item completes on each clock edge where `xfer_req` and `xfer_ack` are both high.
- R5: Each completed item lowers the count by exactly one, for both widths. Reading the count during a run returns the live remaining value.
- R6: When a completed item brings the count to zero, busy and `xfer_req` drop, and done and `irq` go high. Done then stays high until bit 3 is written with 1 or a new run starts. Done reads 0 while a run is in progress.
- R7: A count of zero at start produces exactly 65536 items.
- R8: In byte mode (bit 0 = 0), a count of C produces C items, each with `xfer_wide` = 0.
- R9: In word mode with the odd flag clear, every item has `xfer_wide` = 1.
- R10: In word mode with the odd flag set, the final item has `xfer_wide` = 0 and every earlier item has `xfer_wide` = 1. A count of 1 therefore gives a single byte item.
- R11: While busy, writes to the count bytes, writes to the mode bits and start commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 count low byte, 1 count high byte, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| xfer_req | output | 1 | Transfer request; one item completes per acknowledged cycle |
| xfer_wide | output | 1 | Width of the current item: 1 word, 0 byte |
| xfer_ack | input | 1 | Acknowledge of the current item |
| irq | output | 1 | Completion interrupt, equal to the sticky done flag |

## Verification
The transfer engine is run in byte mode, in word mode with an even length and in word mode with an odd length. Comparing the width sequences of these runs separates the three width rules and shows whether the byte-wide item falls only on the last position. Single-item and zero-load runs test the two count ends: a count of 1 gives one byte item, and a loaded zero gives 65536 items. Acknowledges arrive back-to-back in some runs and in a gapped pattern in others, which shows that items are counted by acknowledge and not by cycle. A stalled run is read mid-way and written to, which exposes the live count and shows that writes during a run are ignored.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  // Control byte bit positions (software visible, see R3)
  localparam int unsigned CTL_WIDE = 0;
  localparam int unsigned CTL_ODD  = 1;
  localparam int unsigned CTL_RUN  = 2;
  localparam int unsigned CTL_DONE = 3;
  localparam int unsigned CTL_BITS = 4;
endpackage

// File: rtl/dxc_count.sv
module dxc_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8,
  localparam int unsigned LANES = CNT_W / BUS_W,
  localparam int unsigned LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LANE_IDX_W-1:0] wr_lane,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic                  busy,
  input  logic                  dec,
  output logic [CNT_W-1:0]      cnt,
  output logic                  last_item
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [LANES-1:0] lane_we;
  logic             cnt_en;

  // one write enable per byte lane; writes are refused while the channel runs
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = wr_en && !busy && (wr_lane == LANE_IDX_W'(g));
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (dec) begin
      cnt_nxt = cnt_q - 1'b1;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) cnt_nxt[i*BUS_W +: BUS_W] = wr_data;
      end
    end
  end

  assign cnt_en = dec || (|lane_we);

  // count has no defined reset value: software loads it before a run
  always_ff @(posedge clk) begin
    if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt       = cnt_q;
  assign last_item = (cnt_q == CNT_W'(1));

  assert_dec_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/dxc_ctrl.sv
module dxc_ctrl
  import dxc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [CTL_BITS-1:0] ctl_wdata,
  input  logic                xfer_ack,
  input  logic                last_item,
  output logic                busy,
  output logic                done,
  output logic                wide_mode,
  output logic                odd_flag,
  output logic                xfer_req,
  output logic                xfer_wide,
  output logic                dec
);
  logic busy_q, busy_nxt, done_q, done_nxt;
  logic wide_q, odd_q, mode_en;
  logic start, clr_done, finish;

  assign start    = ctl_we && ctl_wdata[CTL_RUN] && !busy_q;
  assign clr_done = ctl_we && ctl_wdata[CTL_DONE];
  assign dec      = busy_q && xfer_ack;
  assign finish   = dec && last_item;
  assign mode_en  = ctl_we && !busy_q;

  always_comb begin
    busy_nxt = busy_q;
    done_nxt = done_q;
    if (start) begin
      busy_nxt = 1'b1;
      done_nxt = 1'b0;
    end else if (finish) begin
      busy_nxt = 1'b0;
      done_nxt = 1'b1;
    end else if (clr_done) begin
      done_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      done_q <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (mode_en) begin
      wide_q <= ctl_wdata[CTL_WIDE];
      odd_q  <= ctl_wdata[CTL_ODD];
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign wide_mode = wide_q;
  assign odd_flag  = odd_q;
  assign xfer_req  = busy_q;
  // an odd word-mode run narrows only its final item
  assign xfer_wide = wide_q && !(odd_q && last_item);

  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(xfer_ack && last_item));

  assert_req_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !xfer_req);

  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(wide_q) && $stable(odd_q)));
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
  import dxc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              xfer_req,
  output logic              xfer_wide,
  input  logic              xfer_ack,
  output logic              irq
);
  localparam int unsigned LANES      = CNT_W / BUS_W;
  localparam int unsigned LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(LANES);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             last_item, busy, done, wide_mode, odd_flag, dec;
  logic             cnt_sel, ctl_we;
  logic [BUS_W-1:0] ctl_rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign cnt_sel = reg_addr < CTL_ADDR;
  assign ctl_we  = reg_wr && (reg_addr == CTL_ADDR);

  dxc_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr && cnt_sel),
    .wr_lane   (reg_addr[LANE_IDX_W-1:0]),
    .wr_data   (reg_wdata),
    .busy      (busy),
    .dec       (dec),
    .cnt       (cnt),
    .last_item (last_item)
  );

  dxc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (reg_wdata[CTL_BITS-1:0]),
    .xfer_ack  (xfer_ack),
    .last_item (last_item),
    .busy      (busy),
    .done      (done),
    .wide_mode (wide_mode),
    .odd_flag  (odd_flag),
    .xfer_req  (xfer_req),
    .xfer_wide (xfer_wide),
    .dec       (dec)
  );

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_WIDE] = wide_mode;
    ctl_rd[CTL_ODD]  = odd_flag;
    ctl_rd[CTL_RUN]  = busy;
    ctl_rd[CTL_DONE] = done;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = cnt[i*BUS_W +: BUS_W];
    end
    if (reg_addr == CTL_ADDR) reg_rdata = ctl_rd;
  end

  assign irq = done;

  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> !xfer_req);
endmodule

// File: tb/dma_xfer_count_bench.sv
`timescale 1ns/1ps
module dma_xfer_count_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       xfer_req, xfer_wide, xfer_ack, irq;

  int n_chk  = 0;
  int n_fail = 0;
  int ack_mode = 0;  // 0 hold low, 1 always, 2 gapped
  int cyc = 0;
  bit exp_q[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_xfer_count u_dma_xfer_count (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .xfer_wide(xfer_wide), .xfer_ack(xfer_ack), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // acknowledge driver
  initial begin
    xfer_ack = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      xfer_ack = (ack_mode == 1) || (ack_mode == 2 && (cyc % 3 != 1));
    end
  end

  // monitor: pops expected item widths as items complete
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_req && xfer_ack) begin
        if (exp_q.size() == 0) begin
          check("R4 extra item", 1, 0);
        end else begin
          check("R8/R9/R10 item width", int'(xfer_wide), int'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_items(input int cnt, input bit wide, input bit odd);
    int n = (cnt == 0) ? 65536 : cnt;
    for (int i = 0; i < n; i++) exp_q.push_back(wide && !(odd && i == n - 1));
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (xfer_req && k < 70000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_job(input string tag, input int cnt, input bit wide, input bit odd, input int mode);
    logic [7:0] v;
    ack_mode = mode;
    wr(2'd0, cnt[7:0]);
    wr(2'd1, cnt[15:8]);
    push_items(cnt, wide, odd);
    wr(2'd2, {6'd0, odd, wide} | 8'h04);
    wait_idle();
    check({tag, " R4 all items done"}, exp_q.size(), 0);
    rd(2'd0, v); check({tag, " R6 count lo zero"}, v, 0);
    rd(2'd1, v); check({tag, " R6 count hi zero"}, v, 0);
    rd(2'd2, v); check({tag, " R6 done set busy clear"}, v[3:2], 2'b10);
    check({tag, " R6 irq"}, irq, 1);
    ack_mode = 0;
    exp_q.delete();
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd2, v); check("R1 control after reset", v, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 xfer_req after reset", xfer_req, 0);

    // R2 count byte lanes
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    rd(2'd0, v); check("R2 count low byte", v, 8'hA5);
    rd(2'd1, v); check("R2 count high byte", v, 8'h3C);

    // R3 mode bits read back
    wr(2'd2, 8'h03);
    rd(2'd2, v); check("R3 mode bits", v[1:0], 2'b11);

    // R8 byte mode, gapped acknowledges
    run_job("R8 byte", 7, 1'b0, 1'b0, 2);
    // R6 done sticky, then cleared by bit 3
    repeat (5) @(posedge clk);
    check("R6 irq sticky", irq, 1);
    wr(2'd2, 8'h08);
    check("R6 irq cleared", irq, 0);
    rd(2'd2, v); check("R3 done bit cleared", v[3], 0);

    // R9 word mode even
    run_job("R9 word even", 4, 1'b1, 1'b0, 1);
    // R10 word mode odd, gapped
    run_job("R10 word odd", 5, 1'b1, 1'b1, 2);
    // R10 boundary: single byte item
    run_job("R10 single", 1, 1'b1, 1'b1, 1);

    // R5/R11 stalled run, started while done is still set
    ack_mode = 0;
    wr(2'd0, 8'd5); wr(2'd1, 8'd0);
    push_items(5, 1'b0, 1'b0);
    wr(2'd2, 8'h04);
    repeat (3) @(negedge clk);
    check("R4 request held while stalled", xfer_req, 1);
    rd(2'd2, v); check("R6 done cleared by start, busy", v[3:2], 2'b01);
    @(negedge clk);
    ack_mode = 1;
    repeat (2) @(negedge clk);
    ack_mode = 0;
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R5 live count after two items", v, 3);
    wr(2'd0, 8'h77); wr(2'd1, 8'h11);
    rd(2'd0, v); check("R11 count low write ignored", v, 3);
    rd(2'd1, v); check("R11 count high write ignored", v, 0);
    wr(2'd2, 8'h07);
    rd(2'd2, v); check("R11 mode write ignored", v[1:0], 2'b00);
    check("R11 busy unaffected", v[2], 1);
    ack_mode = 1;
    wait_idle();
    check("R5 stalled run completes", exp_q.size(), 0);
    check("R6 irq after stalled run", irq, 1);
    ack_mode = 0;

    // R7 loaded zero runs the full length
    run_job("R7 zero load", 0, 1'b0, 1'b0, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog: actual still running expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule